// File: doc/BRIEF.md
# Condition Code Evaluator with Set-on-Condition Decode

This block judges one of sixteen 4-bit condition codes against the four integer flags (negative, zero, overflow, carry) and reports whether the condition holds. It reads the flags only and has no path that could write them back.

It serves two instruction contexts, selected by `branch_ctx`:

- **Set-on-condition context.** The block decodes the 16-bit opcode word, checks that it has the set-on-condition shape, and produces a byte that is all ones or all zeros. It also produces a write enable and register index for the case where the destination is a data register.
- **Conditional-branch context.** It decodes the branch opcode shape and flags the always and never codes as illegal conditions.

An upstream decoder presents one opcode per cycle with `in_valid`. All results are registered and appear one cycle later, marked by `valid_out`. Memory destinations are recognised, but their address calculation and extension words belong to other blocks.

Top module: `cc_scc_unit`

## Requirements
- R1: While `rst` is high, every output register clears to zero. The outputs are `valid_out`, `hit`, `result`, `dreg_we`, `dreg_idx`, `no_match` and `bad_cond`.
- R2: `valid_out` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, every other output holds its previous value.
- R3: The condition field is opcode bits [11:8], and `flags` bits [3:0] are N, Z, V, C in that order. `hit` follows this table:

  | Code | Name | True when |
  |------|------|-----------|
  | 0 | always | always |
  | 1 | never | never |
  | 2 | higher | !C & !Z |
  | 3 | lower or same | C \| Z |
  | 4 | carry clear | !C |
  | 5 | carry set | C |
  | 6 | not equal | !Z |
  | 7 | equal | Z |
  | 8 | overflow clear | !V |
  | 9 | overflow set | V |
  | 10 | plus | !N |
  | 11 | minus | N |
  | 12 | greater or equal | N == V |
  | 13 | less than | N != V |
  | 14 | greater than | !Z & (N == V) |
  | 15 | less or equal | Z \| (N != V) |

- R4: For a matched set-on-condition opcode, `result` is 8'hFF when the condition holds and 8'h00 when it does not.
- R5: An opcode that does not fit the pattern of the current context raises `no_match`. In that case `result`, `hit`, `dreg_we`, `dreg_idx` and `bad_cond` are all zero. In set-on-condition context the pattern is bits [15:12]=0101 with bits [7:6]=11.
- R6: For a matched set-on-condition opcode, `dreg_idx` carries bits [2:0]. `dreg_we` is high only when the mode field, bits [5:3], is 000.
- R7: In branch context (`branch_ctx`=1), the pattern is bits [15:12]=0110. For a matched opcode, codes 0000 and 0001 raise `bad_cond` and force `hit` low. Every other code gives `hit` per R3. In this context `result`, `dreg_we` and `dreg_idx` stay zero.
- R8: In set-on-condition context, `bad_cond` is never raised. The always and never codes evaluate normally there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode and flags are valid this cycle |
| branch_ctx | input | 1 | 1 = conditional-branch context, 0 = set-on-condition context |
| opcode | input | 16 | Instruction word |
| flags | input | 4 | N, Z, V, C in bits 3..0 |
| valid_out | output | 1 | Registered outputs are new this cycle |
| hit | output | 1 | Condition holds (and is legal in branch context) |
| result | output | 8 | Set-on-condition byte |
| dreg_we | output | 1 | Write `result` to data register `dreg_idx` |
| dreg_idx | output | 3 | Destination data register index |
| no_match | output | 1 | Opcode does not fit the current context's pattern |
| bad_cond | output | 1 | Always/never code seen in branch context |

## Verification
The hardest situations to reach are the flag combinations where the signed conditions split from each other. Examples are N and V both set with Z clear, or Z set alongside N differing from V. A hand-picked set of flag values tends to miss these. The stimulus therefore sweeps every one of the sixteen codes against every one of the sixteen flag patterns, in both contexts and back to back. Idle cycles with garbage opcodes are interleaved to show that the outputs hold. Near-miss opcodes, each one bit off the expected pattern, cover the no-match path.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [3:0] {
    COND_ALWAYS = 4'h0,
    COND_NEVER  = 4'h1,
    COND_HIGHER = 4'h2,
    COND_LOWSM  = 4'h3,
    COND_CCLR   = 4'h4,
    COND_CSET   = 4'h5,
    COND_NOTEQ  = 4'h6,
    COND_EQUAL  = 4'h7,
    COND_OVCLR  = 4'h8,
    COND_OVSET  = 4'h9,
    COND_PLUS   = 4'hA,
    COND_MINUS  = 4'hB,
    COND_GTEQ   = 4'hC,
    COND_LESS   = 4'hD,
    COND_GREAT  = 4'hE,
    COND_LTEQ   = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;

  localparam int COND_W = 4;

endpackage

// File: rtl/cc_eval.sv
module cc_eval
  import cc_pkg::*;
(
  input  cond_e code,
  input  ccr_t  ccr,
  output logic  holds
);

  logic signed_ge;

  assign signed_ge = ~(ccr.n ^ ccr.v);

  always_comb begin
    unique case (code)
      COND_ALWAYS: holds = 1'b1;
      COND_NEVER:  holds = 1'b0;
      COND_HIGHER: holds = ~ccr.c & ~ccr.z;
      COND_LOWSM:  holds = ccr.c | ccr.z;
      COND_CCLR:   holds = ~ccr.c;
      COND_CSET:   holds = ccr.c;
      COND_NOTEQ:  holds = ~ccr.z;
      COND_EQUAL:  holds = ccr.z;
      COND_OVCLR:  holds = ~ccr.v;
      COND_OVSET:  holds = ccr.v;
      COND_PLUS:   holds = ~ccr.n;
      COND_MINUS:  holds = ccr.n;
      COND_GTEQ:   holds = signed_ge;
      COND_LESS:   holds = ~signed_ge;
      COND_GREAT:  holds = ~ccr.z & signed_ge;
      COND_LTEQ:   holds = ccr.z | ~signed_ge;
      default:     holds = 1'b0;
    endcase
  end

endmodule

// File: rtl/cc_op_decode.sv
module cc_op_decode
  import cc_pkg::*;
#(
  parameter int OPC_W = 16,
  parameter int REG_W = 3
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             branch_ctx,
  output logic             matched,
  output cond_e            code,
  output logic             to_dreg,
  output logic [REG_W-1:0] reg_idx,
  output logic             illegal_branch
);

  localparam int GRP_W   = 4;
  localparam int GRP_LSB = OPC_W - GRP_W;
  localparam int CND_LSB = GRP_LSB - COND_W;
  localparam int SZ_LSB  = CND_LSB - 2;
  localparam int MODE_W  = 3;
  localparam int MODE_LSB = REG_W;

  localparam logic [GRP_W-1:0] GRP_SET    = 4'b0101;
  localparam logic [GRP_W-1:0] GRP_BRANCH = 4'b0110;
  localparam logic [1:0]       SZ_SET     = 2'b11;

  logic [GRP_W-1:0]  grp;
  logic [1:0]        sz;
  logic [MODE_W-1:0] mode;
  logic              set_shape;
  logic              br_shape;

  assign grp  = opcode[OPC_W-1 -: GRP_W];
  assign sz   = opcode[SZ_LSB +: 2];
  assign mode = opcode[MODE_LSB +: MODE_W];
  assign code = cond_e'(opcode[CND_LSB +: COND_W]);

  assign set_shape = (grp == GRP_SET) && (sz == SZ_SET);
  assign br_shape  = (grp == GRP_BRANCH);

  always_comb begin
    matched        = 1'b0;
    to_dreg        = 1'b0;
    reg_idx        = '0;
    illegal_branch = 1'b0;
    if (branch_ctx) begin
      matched        = br_shape;
      illegal_branch = br_shape && ((code == COND_ALWAYS) || (code == COND_NEVER));
    end else begin
      matched = set_shape;
      if (set_shape) begin
        to_dreg = (mode == '0);
        reg_idx = opcode[REG_W-1:0];
      end
    end
  end

endmodule

// File: rtl/cc_scc_unit.sv
module cc_scc_unit
  import cc_pkg::*;
#(
  parameter int OPC_W = 16,
  parameter int RES_W = 8,
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             branch_ctx,
  input  logic [OPC_W-1:0] opcode,
  input  logic [3:0]       flags,
  output logic             valid_out,
  output logic             hit,
  output logic [RES_W-1:0] result,
  output logic             dreg_we,
  output logic [REG_W-1:0] dreg_idx,
  output logic             no_match,
  output logic             bad_cond
);

  logic             matched;
  cond_e            code;
  logic             to_dreg;
  logic [REG_W-1:0] reg_idx;
  logic             illegal_branch;
  logic             holds;

  logic             hit_d;
  logic [RES_W-1:0] result_d;

  cc_op_decode #(
    .OPC_W (OPC_W),
    .REG_W (REG_W)
  ) u_dec (
    .opcode         (opcode),
    .branch_ctx     (branch_ctx),
    .matched        (matched),
    .code           (code),
    .to_dreg        (to_dreg),
    .reg_idx        (reg_idx),
    .illegal_branch (illegal_branch)
  );

  cc_eval u_eval (
    .code  (code),
    .ccr   (ccr_t'(flags)),
    .holds (holds)
  );

  always_comb begin
    hit_d    = matched && holds && !illegal_branch;
    result_d = (matched && !branch_ctx && holds) ? {RES_W{1'b1}} : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      hit       <= 1'b0;
      result    <= '0;
      dreg_we   <= 1'b0;
      dreg_idx  <= '0;
      no_match  <= 1'b0;
      bad_cond  <= 1'b0;
    end else begin
      valid_out <= in_valid;
      if (in_valid) begin
        hit      <= hit_d;
        result   <= result_d;
        dreg_we  <= to_dreg;
        dreg_idx <= reg_idx;
        no_match <= !matched;
        bad_cond <= illegal_branch;
      end
    end
  end

endmodule

// File: rtl/cc_scc_unit_chk.sv
module cc_scc_unit_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             valid_out,
  input logic             hit,
  input logic [RES_W-1:0] result,
  input logic             dreg_we,
  input logic             no_match,
  input logic             bad_cond
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_out && !hit && result == '0 && !dreg_we && !no_match && !bad_cond));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> valid_out);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!valid_out && $stable(result) && $stable(hit) && $stable(no_match)));

  a_r4_result_full: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (result == '0 || result == {RES_W{1'b1}}));

  a_r4_set_means_hit: assert property (@(posedge clk) disable iff (rst)
    (result != '0) |-> hit);

  a_r5_nomatch_quiet: assert property (@(posedge clk) disable iff (rst)
    no_match |-> (result == '0 && !hit && !dreg_we && !bad_cond));

  a_r7_bad_not_taken: assert property (@(posedge clk) disable iff (rst)
    bad_cond |-> (!hit && result == '0 && !dreg_we));

endmodule

bind cc_scc_unit cc_scc_unit_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/cc_scc_unit_test.sv
module cc_scc_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        branch_ctx = 1'b0;
  logic [15:0] opcode = '0;
  logic [3:0]  flags = '0;
  logic        valid_out, hit, dreg_we, no_match, bad_cond;
  logic [7:0]  result;
  logic [2:0]  dreg_idx;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  logic       e_valid, e_hit, e_we, e_nm, e_bad;
  logic [7:0] e_res;
  logic [2:0] e_idx;

  always #10 clk = ~clk;

  cc_scc_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .branch_ctx(branch_ctx),
    .opcode(opcode), .flags(flags), .valid_out(valid_out), .hit(hit),
    .result(result), .dreg_we(dreg_we), .dreg_idx(dreg_idx),
    .no_match(no_match), .bad_cond(bad_cond)
  );

  function automatic bit ref_cond(int cc, logic [3:0] f);
    bit n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cc)
      0: return 1;
      1: return 0;
      2: return !c && !z;
      3: return c || z;
      4: return !c;
      5: return c;
      6: return !z;
      7: return z;
      8: return !v;
      9: return v;
      10: return !n;
      11: return n;
      12: return n == v;
      13: return n != v;
      14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 valid_out", {7'b0, valid_out}, {7'b0, e_valid});
    chk("R3 hit", {7'b0, hit}, {7'b0, e_hit});
    chk("R4 result", result, e_res);
    chk("R5 no_match", {7'b0, no_match}, {7'b0, e_nm});
    chk("R6 dreg_we", {7'b0, dreg_we}, {7'b0, e_we});
    chk("R6 dreg_idx", {5'b0, dreg_idx}, {5'b0, e_idx});
    chk("R7_R8 bad_cond", {7'b0, bad_cond}, {7'b0, e_bad});
  endtask

  // Compare the previous cycle's expectation, then drive new inputs and predict.
  task automatic step(bit v, bit bctx, logic [15:0] op, logic [3:0] f);
    int cc;
    bit c;
    @(negedge clk);
    compare_all();
    in_valid = v; branch_ctx = bctx; opcode = op; flags = f;
    e_valid = v;
    if (v) begin
      cc = int'(op[11:8]);
      c  = ref_cond(cc, f);
      e_hit = 0; e_res = 0; e_we = 0; e_idx = 0; e_nm = 0; e_bad = 0;
      if (bctx) begin
        if (op[15:12] == 4'b0110) begin
          e_bad = (cc < 2);
          e_hit = !e_bad && c;
        end else e_nm = 1;
      end else begin
        if (op[15:12] == 4'b0101 && op[7:6] == 2'b11) begin
          e_hit = c;
          e_res = c ? 8'hFF : 8'h00;
          e_we  = (op[5:3] == 3'b000);
          e_idx = op[2:0];
        end else e_nm = 1;
      end
    end
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    e_valid = 0; e_hit = 0; e_res = 0; e_we = 0; e_idx = 0; e_nm = 0; e_bad = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    compare_all();
    rst = 0;
    step(0, 0, 16'h0000, 4'h0);
    // R3 R4 R6 R8: sweep every code against every flag pattern in set context
    for (int i = 0; i < 256; i++) begin
      logic [2:0] md;
      md = (i % 3 == 0) ? 3'd0 : 3'(i % 8);
      step(1, 0, {4'b0101, 4'(i / 16), 2'b11, md, 3'(i % 8)}, 4'(i % 16));
      if (i % 37 == 0) step(0, 1, 16'hFFFF, 4'hF); // R2: idle cycle holds outputs
    end
    // R3 R7: sweep in branch context
    for (int i = 0; i < 256; i++)
      step(1, 1, {4'b0110, 4'(i / 16), 8'(i * 7)}, 4'(i % 16));
    // R5: near-miss opcodes in each context
    step(1, 0, 16'h57BF, 4'h4);   // size bits 10
    step(1, 0, 16'h577F, 4'h4);   // size bits 01
    step(1, 0, 16'h67C0, 4'h4);   // branch shape in set context
    step(1, 0, 16'h47C0, 4'h4);
    step(1, 1, 16'h50C0, 4'hF);   // set shape in branch context
    step(1, 1, 16'h7012, 4'h0);
    // R6: mode 000 with each register, then a memory mode
    for (int r = 0; r < 8; r++) step(1, 0, {8'h50, 2'b11, 3'b000, 3'(r)}, 4'h0);
    step(1, 0, 16'h51D5, 4'h0);
    // R2: back-to-back then idle
    step(0, 0, 16'h50C0, 4'h0);
    step(0, 0, 16'h50C0, 4'h0);
    // R1: reset in mid-stream clears outputs
    step(1, 0, 16'h50C3, 4'h0);
    @(negedge clk);
    compare_all();
    rst = 1; in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    e_valid = 0; e_hit = 0; e_res = 0; e_we = 0; e_idx = 0; e_nm = 0; e_bad = 0;
    compare_all();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule